// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor three 8-bit general-purpose parallel ports, named A, B and C, behind a small register interface. Port C is handled as two 4-bit halves: the upper half is grouped with port A and the lower half with port B. Each port, and each half of port C, can be set to input or output. Output ports hold the last value written to them. Input ports are sampled straight from the pins whenever they are read.

Software controls the block through one write-only control register that accepts two word formats. A word with bit 7 set is a configuration word. It sets the port directions and always clears every output latch. Configuration words that request a handshake mode are not supported: their direction bits are dropped, but they still clear the latches. A word with bit 7 clear sets or clears one bit of the port C output latch. The processor side uses a shared 8-bit data bus, split into input, output and output-enable signals. Each port pin group is split in the same way.

Top module: `pario_ctrl`

## Requirements
- R1: A write with `wr` high and `csN` low loads `dataIn` on the rising clock edge into the latch picked by `addr`: 0 selects port A, 1 port B, 2 port C, and 3 the control register.
- R2: While `csN` is high, `dataOe` stays low and writes change no latch and no direction.
- R3: A read at address 3 returns 0x00 on `dataOut`. The control register cannot be read back.
- R4: A control word with bit 7 = 1, bits 6:5 = 00 and bit 2 = 0 sets the directions, where 1 means input. Bit 4 sets port A, bit 3 sets the upper half of port C, bit 1 sets port B and bit 0 sets the lower half of port C. Each output-enable bit is high exactly when its pin is an output.
- R5: Every control word with bit 7 = 1 clears the A, B and C output latches to zero, whatever its other bits hold.
- R6: A control word with bit 7 = 1 and either bits 6:5 nonzero or bit 2 = 1 leaves all directions unchanged.
- R7: A control word with bit 7 = 0 writes bit 0 into the port C latch bit whose index is given by bits 3:1. Bits 6:4 are ignored. This works whether the target half is an input or an output, and no other latch bit changes.
- R8: A written output value stays on the port outputs until the latch is written again, cleared, or reset.
- R9: A read of a port returns the pins for input ports and the latch for output ports. For port C this choice is made separately for each half.
- R10: After reset, every port is an input (all output enables low) and every latch is zero.
- R11: `dataOe` is high exactly while `rd` is high and `csN` is low. At all other times `dataOut` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | Register select |
| dataIn | input | 8 | Data bus from the processor |
| dataOut | output | 8 | Data bus to the processor |
| dataOe | output | 1 | Data bus drive enable |
| portAIn | input | 8 | Port A pin levels |
| portAOut | output | 8 | Port A output latch |
| portAOe | output | 8 | Port A per-pin drive enable |
| portBIn | input | 8 | Port B pin levels |
| portBOut | output | 8 | Port B output latch |
| portBOe | output | 8 | Port B per-pin drive enable |
| portCIn | input | 8 | Port C pin levels |
| portCOut | output | 8 | Port C output latch |
| portCOe | output | 8 | Port C per-pin drive enable |

## Verification
The assertions assume the bus strobes are stable over each clock edge and that `rd` and `wr` are never high together. They also assume the pin inputs change only between accesses. The stimulus applies every strobe, address and pin value on the falling edge and never raises both strobes in the same cycle. Set/reset words always carry a bit index in range, and some carry nonzero filler in bits 6:4 so that R7 is tested with it present.

// File: rtl/pario_pkg.sv
package pario_pkg;
  localparam int PortW = 8;
  localparam int HalfW = PortW / 2;
  localparam int IdxW  = $clog2(PortW);

  typedef enum logic [1:0] {
    SelA   = 2'd0,
    SelB   = 2'd1,
    SelC   = 2'd2,
    SelCtl = 2'd3
  } portSel_t;

  // strobes from the bus decoder to the datapath
  typedef struct packed {
    logic            wrA;
    logic            wrB;
    logic            wrC;
    logic            clrAll;
    logic            setDir;
    logic [3:0]      dirBits;  // {A, C upper, B, C lower}, 1 = input
    logic            bitWr;
    logic [IdxW-1:0] bitIdx;
    logic            bitVal;
    logic            rdEn;
  } ctlStrobes_t;
endpackage

// File: rtl/pario_ctl.sv
module pario_ctl
  import pario_pkg::*;
(
  input  logic             csN,
  input  logic             rd,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [PortW-1:0] dataIn,
  output ctlStrobes_t      strb
);
  logic     access;
  logic     ctrlWr;
  logic     basicOk;
  portSel_t sel;

  always_comb begin
    sel     = portSel_t'(addr);
    access  = wr && !csN;
    ctrlWr  = access && (sel == SelCtl);
    basicOk = (dataIn[6:5] == 2'b00) && !dataIn[2];

    strb.wrA     = access && (sel == SelA);
    strb.wrB     = access && (sel == SelB);
    strb.wrC     = access && (sel == SelC);
    strb.clrAll  = ctrlWr && dataIn[7];
    strb.setDir  = ctrlWr && dataIn[7] && basicOk;
    strb.dirBits = {dataIn[4], dataIn[3], dataIn[1], dataIn[0]};
    strb.bitWr   = ctrlWr && !dataIn[7];
    strb.bitIdx  = dataIn[IdxW:1];
    strb.bitVal  = dataIn[0];
    strb.rdEn    = rd && !csN;
  end
endmodule

// File: rtl/pario_dp.sv
module pario_dp
  import pario_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobes_t      strb,
  input  logic [1:0]       addr,
  input  logic [PortW-1:0] dataIn,
  output logic [PortW-1:0] dataOut,
  input  logic [PortW-1:0] portAIn,
  output logic [PortW-1:0] portAOut,
  output logic [PortW-1:0] portAOe,
  input  logic [PortW-1:0] portBIn,
  output logic [PortW-1:0] portBOut,
  output logic [PortW-1:0] portBOe,
  input  logic [PortW-1:0] portCIn,
  output logic [PortW-1:0] portCOut,
  output logic [PortW-1:0] portCOe
);
  logic [PortW-1:0] latA, latB, latC;
  logic             inA, inCu, inB, inCl;
  logic [PortW-1:0] readC;

  always_ff @(posedge clk) begin
    if (rst) begin
      latA <= '0;
      latB <= '0;
      latC <= '0;
      inA  <= 1'b1;
      inCu <= 1'b1;
      inB  <= 1'b1;
      inCl <= 1'b1;
    end else begin
      if (strb.clrAll) begin
        latA <= '0;
        latB <= '0;
        latC <= '0;
      end else begin
        if (strb.wrA) latA <= dataIn;
        if (strb.wrB) latB <= dataIn;
        if (strb.wrC) latC <= dataIn;
        if (strb.bitWr) latC[strb.bitIdx] <= strb.bitVal;
      end
      if (strb.setDir) {inA, inCu, inB, inCl} <= strb.dirBits;
    end
  end

  // each half of port C picks pins or latch on its own
  for (genvar h = 0; h < 2; h++) begin : g_cHalf
    logic halfIn;
    assign halfIn = (h == 1) ? inCu : inCl;
    assign readC[h*HalfW +: HalfW]   = halfIn ? portCIn[h*HalfW +: HalfW] : latC[h*HalfW +: HalfW];
    assign portCOe[h*HalfW +: HalfW] = {HalfW{!halfIn}};
  end

  assign portAOut = latA;
  assign portBOut = latB;
  assign portCOut = latC;
  assign portAOe  = {PortW{!inA}};
  assign portBOe  = {PortW{!inB}};

  always_comb begin
    dataOut = '0;
    if (strb.rdEn) begin
      unique case (portSel_t'(addr))
        SelA:    dataOut = inA ? portAIn : latA;
        SelB:    dataOut = inB ? portBIn : latB;
        SelC:    dataOut = readC;
        default: dataOut = '0;
      endcase
    end
  end
endmodule

// File: rtl/pario_ctrl.sv
module pario_ctrl
  import pario_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             csN,
  input  logic             rd,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [PortW-1:0] dataIn,
  output logic [PortW-1:0] dataOut,
  output logic             dataOe,
  input  logic [PortW-1:0] portAIn,
  output logic [PortW-1:0] portAOut,
  output logic [PortW-1:0] portAOe,
  input  logic [PortW-1:0] portBIn,
  output logic [PortW-1:0] portBOut,
  output logic [PortW-1:0] portBOe,
  input  logic [PortW-1:0] portCIn,
  output logic [PortW-1:0] portCOut,
  output logic [PortW-1:0] portCOe
);
  ctlStrobes_t strb;

  pario_ctl u_ctl (
    .csN(csN), .rd(rd), .wr(wr), .addr(addr), .dataIn(dataIn), .strb(strb)
  );

  pario_dp u_dp (
    .clk(clk), .rst(rst), .strb(strb), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut),
    .portAIn(portAIn), .portAOut(portAOut), .portAOe(portAOe),
    .portBIn(portBIn), .portBOut(portBOut), .portBOe(portBOe),
    .portCIn(portCIn), .portCOut(portCOut), .portCOe(portCOe)
  );

  assign dataOe = strb.rdEn;
endmodule

// File: rtl/pario_ctrl_chk.sv
module pario_ctrl_chk
  import pario_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             csN,
  input logic             rd,
  input logic             wr,
  input logic [1:0]       addr,
  input logic [PortW-1:0] dataIn,
  input logic [PortW-1:0] dataOut,
  input logic             dataOe,
  input logic [PortW-1:0] portAOut,
  input logic [PortW-1:0] portAOe,
  input logic [PortW-1:0] portBOut,
  input logic [PortW-1:0] portBOe,
  input logic [PortW-1:0] portCOut,
  input logic [PortW-1:0] portCOe
);
  logic ctlWrite;
  assign ctlWrite = wr && !csN && (addr == 2'd3);

  a_r2_no_drive_unselected: assert property (@(posedge clk) disable iff (rst)
    csN |-> !dataOe);

  a_r2_no_write_unselected: assert property (@(posedge clk) disable iff (rst)
    csN |=> ($stable(portAOut) && $stable(portBOut) && $stable(portCOut) &&
             $stable(portAOe) && $stable(portBOe) && $stable(portCOe)));

  a_r3_ctl_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd && !csN && addr == 2'd3) |-> (dataOut == '0));

  a_r5_mode_clears: assert property (@(posedge clk) disable iff (rst)
    (ctlWrite && dataIn[7]) |=> (portAOut == '0 && portBOut == '0 && portCOut == '0));

  a_r6_bad_mode_keeps_dir: assert property (@(posedge clk) disable iff (rst)
    (ctlWrite && dataIn[7] && (dataIn[6:5] != 2'b00 || dataIn[2]))
      |=> ($stable(portAOe) && $stable(portBOe) && $stable(portCOe)));

  a_r7_bit_write: assert property (@(posedge clk) disable iff (rst)
    (ctlWrite && !dataIn[7]) |=>
      (portCOut[$past(dataIn[IdxW:1])] == $past(dataIn[0]) &&
       $stable(portAOut) && $stable(portBOut) && $stable(portCOe)));

  a_r11_idle_bus_quiet: assert property (@(posedge clk) disable iff (rst)
    !(rd && !csN) |-> (!dataOe && dataOut == '0));
endmodule

bind pario_ctrl pario_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .csN(csN), .rd(rd), .wr(wr), .addr(addr),
  .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
  .portAOut(portAOut), .portAOe(portAOe),
  .portBOut(portBOut), .portBOe(portBOe),
  .portCOut(portCOut), .portCOe(portCOe)
);

// File: tb/pario_ctrl_bench.sv
module pario_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       csN = 1'b1;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dataOut;
  logic       dataOe;
  logic [7:0] portAIn = 8'h5A, portBIn = 8'hC3, portCIn = 8'h96;
  logic [7:0] portAOut, portAOe, portBOut, portBOe, portCOut, portCOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pario_ctrl u_pario_ctrl (
    .clk(clk), .rst(rst), .csN(csN), .rd(rd), .wr(wr), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .portAIn(portAIn), .portAOut(portAOut), .portAOe(portAOe),
    .portBIn(portBIn), .portBOut(portBOut), .portBOe(portBOe),
    .portCIn(portCIn), .portCOut(portCOut), .portCOe(portCOe)
  );

  typedef struct packed {
    logic       isWr;
    logic [1:0] a;
    logic [7:0] d;    // write data, or expected read value
    logic [7:0] req;  // requirement number for the message
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 8'h5A, 8'd9},   // R9 input pins after reset
    '{1'b0, 2'd1, 8'hC3, 8'd9},
    '{1'b0, 2'd2, 8'h96, 8'd9},
    '{1'b0, 2'd3, 8'h00, 8'd3},   // R3 control not readable
    '{1'b1, 2'd3, 8'h80, 8'd4},   // R4 all outputs
    '{1'b1, 2'd0, 8'h11, 8'd1},   // R1
    '{1'b1, 2'd1, 8'h22, 8'd1},
    '{1'b1, 2'd2, 8'h33, 8'd1},
    '{1'b0, 2'd0, 8'h11, 8'd1},
    '{1'b0, 2'd1, 8'h22, 8'd1},
    '{1'b0, 2'd2, 8'h33, 8'd1},
    '{1'b1, 2'd3, 8'h0F, 8'd7},   // R7 set C bit 7
    '{1'b0, 2'd2, 8'hB3, 8'd7},
    '{1'b1, 2'd3, 8'h70, 8'd7},   // R7 clear C bit 0, filler in 6:4
    '{1'b0, 2'd2, 8'hB2, 8'd7},
    '{1'b1, 2'd3, 8'h89, 8'd5},   // R5 clears, both C halves input
    '{1'b0, 2'd0, 8'h00, 8'd5},
    '{1'b0, 2'd1, 8'h00, 8'd5},
    '{1'b0, 2'd2, 8'h96, 8'd9},
    '{1'b1, 2'd3, 8'h88, 8'd4},   // R4 upper C in, lower out
    '{1'b1, 2'd2, 8'hFF, 8'd9},
    '{1'b0, 2'd2, 8'h9F, 8'd9},   // R9 merged per half
    '{1'b1, 2'd3, 8'hA0, 8'd6},   // R6 handshake mode request
    '{1'b0, 2'd2, 8'h90, 8'd6},   // R5 cleared, R6 directions kept
    '{1'b0, 2'd0, 8'h00, 8'd6}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    csN = !sel; wr = 1'b1; addr = a; dataIn = d;
    @(negedge clk);
    csN = 1'b1; wr = 1'b0; dataIn = 8'h00;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    csN = 1'b0; rd = 1'b1; addr = a;
    #1;
    d = dataOut; oe = dataOe;
    @(negedge clk);
    csN = 1'b1; rd = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic oe;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 A oe", portAOe, 8'h00);
    check("R10 B oe", portBOe, 8'h00);
    check("R10 C oe", portCOe, 8'h00);
    check("R10 latches", portAOut | portBOut | portCOut, 8'h00);
    check("R11 idle oe", {7'd0, dataOe}, 8'h00);
    check("R11 idle data", dataOut, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isWr) busWrite(VECS[i].a, VECS[i].d, 1'b1);
      else begin
        busRead(VECS[i].a, r, oe);
        check($sformatf("R%0d vec %0d", VECS[i].req, i), r, VECS[i].d);
        check("R11 read oe", {7'd0, oe}, 8'h01);
      end
    end

    // R6: directions kept after the unsupported word (A, B out; C upper in, lower out)
    check("R6 A oe", portAOe, 8'hFF);
    check("R6 C oe", portCOe, 8'h0F);

    // R4 full direction set: A in, B out, C upper out, C lower in
    busWrite(2'd3, 8'h91, 1'b1);
    check("R4 A oe", portAOe, 8'h00);
    check("R4 B oe", portBOe, 8'hFF);
    check("R4 C oe", portCOe, 8'hF0);

    // R7 set/reset on an input half still reaches the latch
    busWrite(2'd3, 8'h05, 1'b1);   // index 2, value 1
    check("R7 input half latch", portCOut, 8'h04);
    busRead(2'd2, r, oe);
    check("R9 C merged", r, 8'h06);

    // R8 latched value persists
    busWrite(2'd1, 8'hA5, 1'b1);
    repeat (5) @(negedge clk);
    check("R8 B held", portBOut, 8'hA5);

    // R2 chip select high blocks writes and bus drive
    busWrite(2'd1, 8'h3C, 1'b0);
    busWrite(2'd3, 8'h80, 1'b0);
    check("R2 B unchanged", portBOut, 8'hA5);
    check("R2 dir unchanged", portAOe, 8'h00);
    @(negedge clk);
    rd = 1'b1; addr = 2'd1; csN = 1'b1;
    #1;
    check("R2 oe off", {7'd0, dataOe}, 8'h00);
    check("R11 data off", dataOut, 8'h00);
    @(negedge clk);
    rd = 1'b0;

    // R1 port A write while A is input reaches latch; read shows pins
    busWrite(2'd0, 8'h77, 1'b1);
    check("R1 A latch", portAOut, 8'h77);
    busRead(2'd0, r, oe);
    check("R9 A pins", r, 8'h5A);

    // R10 reset returns everything to inputs and zero
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 B oe after reset", portBOe, 8'h00);
    check("R10 B latch after reset", portBOut, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule